// File: doc/BRIEF.md
# DDR Command Turnaround Timing Checker

This block watches a decoded DDR3/DDR4 command stream, one command per controller clock, and checks the turnaround spacing between column commands. Each command has a kind (READ, WRITE or other), a rank, a DIMM, a bank group and a burst mode: BL8, or BC4 chosen on the fly. For every new READ or WRITE the block measures how many clocks have passed since the most recent READ and since the most recent WRITE. It then compares those gaps with minimum intervals derived from the programmed latencies. When a minimum is not met, it raises a one-clock violation flag in the same cycle. The flag comes with a rule code, the measured gap and the required minimum.

The timing values are register inputs in clock cycles. They are copied on a configuration-load strobe, and the same strobe clears the command history. The block is a passive monitor. It sits beside a memory controller or in a verification environment and never alters the command stream.

Top module: `ddr_turnaround_chk`

## Requirements
- R1: After reset, and after a configuration load, the first READ or WRITE is not checked and raises no flag. While reset is held, `viol_pulse` is 0.
- R2: A WRITE that follows a BL8 READ to the same DIMM and rank needs a gap of at least CL − CWL + 2 + tCCD. The burst mode is the one of the earlier READ.
- R3: A WRITE that follows a BC4 READ to the same DIMM and rank needs a gap of at least CL − CWL + 2 + floor(tCCD/2).
- R4: A READ that follows a WRITE in the same group needs a gap of at least CWL + tWTR + 4 when the WRITE was BL8, and CWL + tWTR + 2 when it was BC4.
- R5: A WRITE that follows a WRITE in the same group needs a gap of at least AL + CWL − write preamble, clamped at 0.
- R6: Across ranks of one DIMM, a READ-then-WRITE pair is checked against `cfg_rtw_dr` and a WRITE-then-READ pair against `cfg_wtr_dr`. Across DIMMs the two minimums are `cfg_rtw_dd` and `cfg_wtr_dd`. WRITE-to-WRITE has no check across ranks or DIMMs.
- R7: With `cfg_ddr4`=1, a group is one DIMM, rank and bank group. A READ or WRITE after a WRITE to another bank group of the same rank is then not checked. With `cfg_ddr4`=0, a group is one DIMM and rank, and `cmd_bg` is ignored.
- R8: `viol_code` values are: 0 none, 1 READ→WRITE same rank, 2 READ→WRITE other rank, 3 READ→WRITE other DIMM, 4 WRITE→READ same group, 5 WRITE→READ other rank, 6 WRITE→READ other DIMM, 7 WRITE→WRITE.
- R9: The gap is the clock count between the two commands: adjacent cycles give 1. A gap equal to the minimum passes. A violation drives `viol_pulse`, `viol_code`, `viol_gap` and `viol_min` in the same cycle as the offending command and for that cycle only. Otherwise all four are 0. Every command is recorded as history, including one that violates.
- R10: Asserting `cfg_load` copies all configuration inputs and clears both histories. The new values apply from the next cycle. A command presented in the load cycle is neither checked nor recorded.
- R11: When one WRITE breaks both a READ→WRITE rule and the WRITE→WRITE rule, the READ→WRITE code, gap and minimum are reported.
- R12: The measured gap saturates at 255. A long idle time therefore never wraps around into a short gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe: copy configuration, clear history |
| cfg_ddr4 | input | 1 | 1 = DDR4 bank-group rules, 0 = DDR3 |
| cfg_cl | input | 6 | CAS read latency, clocks |
| cfg_cwl | input | 6 | CAS write latency, clocks |
| cfg_al | input | 6 | Additive latency, clocks |
| cfg_ccd | input | 6 | Column-to-column delay, clocks |
| cfg_wtr | input | 6 | Write-to-read internal delay, clocks |
| cfg_wpre | input | 6 | Write preamble, clocks |
| cfg_rtw_dr | input | 6 | READ→WRITE minimum, other rank |
| cfg_rtw_dd | input | 6 | READ→WRITE minimum, other DIMM |
| cfg_wtr_dr | input | 6 | WRITE→READ minimum, other rank |
| cfg_wtr_dd | input | 6 | WRITE→READ minimum, other DIMM |
| cmd_kind | input | 2 | 01 READ, 10 WRITE, other values ignored |
| cmd_rank | input | 2 | Target rank |
| cmd_dimm | input | 1 | Target DIMM |
| cmd_bg | input | 2 | Target bank group |
| cmd_bc4 | input | 1 | 1 = BC4 burst, 0 = BL8 |
| viol_pulse | output | 1 | One-clock violation flag |
| viol_code | output | 3 | Broken rule (R8 encoding) |
| viol_gap | output | 8 | Measured gap of the broken rule |
| viol_min | output | 8 | Required minimum of the broken rule |

## Verification
A WRITE is judged against the last READ and against the last WRITE at once. The READ→WRITE check and the WRITE→WRITE check can therefore fail in the same cycle. The bench provokes this with a WRITE, a READ one clock later, and a second WRITE two clocks after that READ, so that both gaps are short. It expects code 1 with the READ gap and its minimum, never code 7. A second collision puts a command on the configuration-load cycle. The bench expects no flag on that cycle, and no flag from the WRITE that follows, which shows that neither the old history nor the load-cycle command survived.

// File: rtl/ddr_ta_pkg.sv
package ddr_ta_pkg;

  localparam int TW = 6;          // width of every timing field
  localparam int GW = TW + 2;     // width of gaps and minimums

  typedef logic [1:0] kind_t;
  localparam kind_t K_RD = 2'b01;
  localparam kind_t K_WR = 2'b10;

  typedef enum logic [2:0] {
    V_NONE   = 3'd0,
    V_RTW_SR = 3'd1,
    V_RTW_DR = 3'd2,
    V_RTW_DD = 3'd3,
    V_WTR_SG = 3'd4,
    V_WTR_DR = 3'd5,
    V_WTR_DD = 3'd6,
    V_WTW    = 3'd7
  } vcode_t;

  typedef struct packed {
    logic          ddr4;
    logic [TW-1:0] cl;
    logic [TW-1:0] cwl;
    logic [TW-1:0] al;
    logic [TW-1:0] ccd;
    logic [TW-1:0] wtr;
    logic [TW-1:0] wpre;
    logic [TW-1:0] rtw_dr;
    logic [TW-1:0] rtw_dd;
    logic [TW-1:0] wtr_dr;
    logic [TW-1:0] wtr_dd;
  } cfg_t;

  function automatic logic [GW-1:0] clamp_gap(input int v);
    if (v < 0) return '0;
    if (v > (1 << GW) - 1) return '1;
    return v[GW-1:0];
  endfunction

  // READ then WRITE, same rank: CL - CWL + 2 + (BC4 ? CCD/2 : CCD)
  function automatic logic [GW-1:0] min_rtw_same(input logic [TW-1:0] cl,
      input logic [TW-1:0] cwl, input logic [TW-1:0] ccd, input logic bc4);
    int v;
    v = int'(cl) - int'(cwl) + 2 + (bc4 ? int'(ccd >> 1) : int'(ccd));
    return clamp_gap(v);
  endfunction

  // WRITE then READ, same group: CWL + WTR + half the burst length
  function automatic logic [GW-1:0] min_wtr_same(input logic [TW-1:0] cwl,
      input logic [TW-1:0] wtr, input logic bc4);
    int v;
    v = int'(cwl) + int'(wtr) + (bc4 ? 2 : 4);
    return clamp_gap(v);
  endfunction

  // WRITE then WRITE, same group: write latency minus preamble
  function automatic logic [GW-1:0] min_wtw(input logic [TW-1:0] al,
      input logic [TW-1:0] cwl, input logic [TW-1:0] wpre);
    int v;
    v = int'(al) + int'(cwl) - int'(wpre);
    return clamp_gap(v);
  endfunction

endpackage

// File: rtl/ddr_ta_cfg.sv
module ddr_ta_cfg
  import ddr_ta_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);

  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/ddr_ta_hist.sv
module ddr_ta_hist #(
  parameter int RW  = 2,
  parameter int DW  = 1,
  parameter int BGW = 2,
  parameter int GW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           capture_i,
  input  logic [RW-1:0]  rank_i,
  input  logic [DW-1:0]  dimm_i,
  input  logic [BGW-1:0] bg_i,
  input  logic           bc4_i,
  output logic           valid_o,
  output logic [GW-1:0]  age_o,
  output logic [RW-1:0]  rank_o,
  output logic [DW-1:0]  dimm_o,
  output logic [BGW-1:0] bg_o,
  output logic           bc4_o
);

  logic           valid_q;
  logic [GW-1:0]  age_q;
  logic [RW-1:0]  rank_q;
  logic [DW-1:0]  dimm_q;
  logic [BGW-1:0] bg_q;
  logic           bc4_q;
  logic           age_at_max;

  assign age_at_max = (age_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      valid_q <= 1'b0;
      age_q   <= '0;
      rank_q  <= '0;
      dimm_q  <= '0;
      bg_q    <= '0;
      bc4_q   <= 1'b0;
    end else if (capture_i) begin
      valid_q <= 1'b1;
      age_q   <= GW'(1);
      rank_q  <= rank_i;
      dimm_q  <= dimm_i;
      bg_q    <= bg_i;
      bc4_q   <= bc4_i;
    end else if (!age_at_max) begin
      age_q   <= age_q + 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign age_o   = age_q;
  assign rank_o  = rank_q;
  assign dimm_o  = dimm_q;
  assign bg_o    = bg_q;
  assign bc4_o   = bc4_q;

  // R9: a recorded command starts its gap count at one clock
  a_r9_capture_age: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !clr_i) |=> (valid_o && age_o == GW'(1)));

  // R12: the gap count holds at its ceiling instead of wrapping
  a_r12_age_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (age_at_max && !capture_i && !clr_i) |=> (age_o == '1));

endmodule

// File: rtl/ddr_ta_judge.sv
module ddr_ta_judge
  import ddr_ta_pkg::*;
#(
  parameter int RW  = 2,
  parameter int DW  = 1,
  parameter int BGW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cfg_t           cfg_i,
  input  logic           active_i,
  input  kind_t          kind_i,
  input  logic [RW-1:0]  rank_i,
  input  logic [DW-1:0]  dimm_i,
  input  logic [BGW-1:0] bg_i,
  input  logic           rd_valid_i,
  input  logic [GW-1:0]  rd_age_i,
  input  logic [RW-1:0]  rd_rank_i,
  input  logic [DW-1:0]  rd_dimm_i,
  input  logic           rd_bc4_i,
  input  logic           wr_valid_i,
  input  logic [GW-1:0]  wr_age_i,
  input  logic [RW-1:0]  wr_rank_i,
  input  logic [DW-1:0]  wr_dimm_i,
  input  logic [BGW-1:0] wr_bg_i,
  input  logic           wr_bc4_i,
  output logic           pulse_o,
  output vcode_t         code_o,
  output logic [GW-1:0]  gap_o,
  output logic [GW-1:0]  min_o
);

  logic is_rd, is_wr;
  logic rd_same_dimm, rd_same_rank;
  logic wr_same_dimm, wr_same_rank, wr_same_grp;

  assign is_rd = active_i && (kind_i == K_RD);
  assign is_wr = active_i && (kind_i == K_WR);

  assign rd_same_dimm = (dimm_i == rd_dimm_i);
  assign rd_same_rank = rd_same_dimm && (rank_i == rd_rank_i);
  assign wr_same_dimm = (dimm_i == wr_dimm_i);
  assign wr_same_rank = wr_same_dimm && (rank_i == wr_rank_i);
  assign wr_same_grp  = wr_same_rank && (!cfg_i.ddr4 || (bg_i == wr_bg_i));

  // read-to-write rule
  logic          rtw_chk, rtw_fail;
  vcode_t        rtw_code;
  logic [GW-1:0] rtw_min;

  always_comb begin
    if (rd_same_rank) begin
      rtw_code = V_RTW_SR;
      rtw_min  = min_rtw_same(cfg_i.cl, cfg_i.cwl, cfg_i.ccd, rd_bc4_i);
    end else if (rd_same_dimm) begin
      rtw_code = V_RTW_DR;
      rtw_min  = GW'(cfg_i.rtw_dr);
    end else begin
      rtw_code = V_RTW_DD;
      rtw_min  = GW'(cfg_i.rtw_dd);
    end
  end

  assign rtw_chk  = is_wr && rd_valid_i;
  assign rtw_fail = rtw_chk && (rd_age_i < rtw_min);

  // write-to-write rule
  logic          wtw_chk, wtw_fail;
  logic [GW-1:0] wtw_min;

  assign wtw_min  = min_wtw(cfg_i.al, cfg_i.cwl, cfg_i.wpre);
  assign wtw_chk  = is_wr && wr_valid_i && wr_same_grp;
  assign wtw_fail = wtw_chk && (wr_age_i < wtw_min);

  // write-to-read rule
  logic          wtr_chk, wtr_fail;
  vcode_t        wtr_code;
  logic [GW-1:0] wtr_min;

  always_comb begin
    if (wr_same_grp) begin
      wtr_code = V_WTR_SG;
      wtr_min  = min_wtr_same(cfg_i.cwl, cfg_i.wtr, wr_bc4_i);
    end else if (wr_same_dimm) begin
      wtr_code = V_WTR_DR;
      wtr_min  = GW'(cfg_i.wtr_dr);
    end else begin
      wtr_code = V_WTR_DD;
      wtr_min  = GW'(cfg_i.wtr_dd);
    end
  end

  // another bank group of the same rank is not checked
  assign wtr_chk  = is_rd && wr_valid_i && (wr_same_grp || !wr_same_rank);
  assign wtr_fail = wtr_chk && (wr_age_i < wtr_min);

  always_comb begin
    pulse_o = 1'b0;
    code_o  = V_NONE;
    gap_o   = '0;
    min_o   = '0;
    if (rtw_fail) begin
      pulse_o = 1'b1;
      code_o  = rtw_code;
      gap_o   = rd_age_i;
      min_o   = rtw_min;
    end else if (wtw_fail) begin
      pulse_o = 1'b1;
      code_o  = V_WTW;
      gap_o   = wr_age_i;
      min_o   = wtw_min;
    end else if (wtr_fail) begin
      pulse_o = 1'b1;
      code_o  = wtr_code;
      gap_o   = wr_age_i;
      min_o   = wtr_min;
    end
  end

  // R9: a reported gap is always short of its minimum
  a_r9_gap_below_min: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (gap_o < min_o));

  // R11: a double failure on one WRITE never reports the write-to-write code
  a_r11_rtw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rtw_fail && wtw_fail) |-> (code_o != V_WTW && gap_o == rd_age_i));

  // R7: a READ to another bank group of a DDR4 rank raises nothing
  a_r7_other_bg_free: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && cfg_i.ddr4 && wr_same_rank && bg_i != wr_bg_i) |-> !pulse_o);

endmodule

// File: rtl/ddr_turnaround_chk.sv
module ddr_turnaround_chk
  import ddr_ta_pkg::*;
#(
  parameter int RW  = 2,
  parameter int DW  = 1,
  parameter int BGW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic           cfg_ddr4,
  input  logic [TW-1:0]  cfg_cl,
  input  logic [TW-1:0]  cfg_cwl,
  input  logic [TW-1:0]  cfg_al,
  input  logic [TW-1:0]  cfg_ccd,
  input  logic [TW-1:0]  cfg_wtr,
  input  logic [TW-1:0]  cfg_wpre,
  input  logic [TW-1:0]  cfg_rtw_dr,
  input  logic [TW-1:0]  cfg_rtw_dd,
  input  logic [TW-1:0]  cfg_wtr_dr,
  input  logic [TW-1:0]  cfg_wtr_dd,
  input  logic [1:0]     cmd_kind,
  input  logic [RW-1:0]  cmd_rank,
  input  logic [DW-1:0]  cmd_dimm,
  input  logic [BGW-1:0] cmd_bg,
  input  logic           cmd_bc4,
  output logic           viol_pulse,
  output logic [2:0]     viol_code,
  output logic [GW-1:0]  viol_gap,
  output logic [GW-1:0]  viol_min
);

  localparam int NHIST = 2;   // index 0: last READ, index 1: last WRITE

  cfg_t cfg_in, cfg_cur;

  assign cfg_in = '{ddr4: cfg_ddr4, cl: cfg_cl, cwl: cfg_cwl, al: cfg_al,
                    ccd: cfg_ccd, wtr: cfg_wtr, wpre: cfg_wpre,
                    rtw_dr: cfg_rtw_dr, rtw_dd: cfg_rtw_dd,
                    wtr_dr: cfg_wtr_dr, wtr_dd: cfg_wtr_dd};

  ddr_ta_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cfg_load),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_cur)
  );

  logic           h_valid [NHIST];
  logic [GW-1:0]  h_age   [NHIST];
  logic [RW-1:0]  h_rank  [NHIST];
  logic [DW-1:0]  h_dimm  [NHIST];
  logic [BGW-1:0] h_bg    [NHIST];
  logic           h_bc4   [NHIST];
  logic           h_cap   [NHIST];

  for (genvar k = 0; k < NHIST; k++) begin : g_hist
    localparam kind_t KSEL = (k == 0) ? K_RD : K_WR;
    assign h_cap[k] = !cfg_load && (cmd_kind == KSEL);
    ddr_ta_hist #(.RW(RW), .DW(DW), .BGW(BGW), .GW(GW)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (cfg_load),
      .capture_i (h_cap[k]),
      .rank_i    (cmd_rank),
      .dimm_i    (cmd_dimm),
      .bg_i      (cmd_bg),
      .bc4_i     (cmd_bc4),
      .valid_o   (h_valid[k]),
      .age_o     (h_age[k]),
      .rank_o    (h_rank[k]),
      .dimm_o    (h_dimm[k]),
      .bg_o      (h_bg[k]),
      .bc4_o     (h_bc4[k])
    );
  end

  vcode_t j_code;

  ddr_ta_judge #(.RW(RW), .DW(DW), .BGW(BGW)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg_cur),
    .active_i   (!cfg_load),
    .kind_i     (cmd_kind),
    .rank_i     (cmd_rank),
    .dimm_i     (cmd_dimm),
    .bg_i       (cmd_bg),
    .rd_valid_i (h_valid[0]),
    .rd_age_i   (h_age[0]),
    .rd_rank_i  (h_rank[0]),
    .rd_dimm_i  (h_dimm[0]),
    .rd_bc4_i   (h_bc4[0]),
    .wr_valid_i (h_valid[1]),
    .wr_age_i   (h_age[1]),
    .wr_rank_i  (h_rank[1]),
    .wr_dimm_i  (h_dimm[1]),
    .wr_bg_i    (h_bg[1]),
    .wr_bc4_i   (h_bc4[1]),
    .pulse_o    (viol_pulse),
    .code_o     (j_code),
    .gap_o      (viol_gap),
    .min_o      (viol_min)
  );

  assign viol_code = j_code;

  // R10: the cycle after a load has empty history, so no flag
  a_r10_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !viol_pulse);

  // R1: only a READ or WRITE can raise a flag
  a_r1_flag_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (cmd_kind == K_RD || cmd_kind == K_WR));

  // R8: a flag always carries a rule code, no flag carries none
  a_r8_code_matches_flag: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse == (viol_code != 3'd0));

  // R9: the history seen by the judge never loses its entry between commands
  a_r9_hist_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid[0] && !cfg_load) |=> h_valid[0]);

endmodule

// File: tb/tb_ddr_turnaround_chk.sv
module tb_ddr_turnaround_chk;

  localparam logic [1:0] KR = 2'b01, KW = 2'b10, KO = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_ddr4 = 1'b1;
  logic [5:0] cfg_cl = 6'd11, cfg_cwl = 6'd8, cfg_al = 6'd0, cfg_ccd = 6'd4;
  logic [5:0] cfg_wtr = 6'd6, cfg_wpre = 6'd1;
  logic [5:0] cfg_rtw_dr = 6'd7, cfg_rtw_dd = 6'd9, cfg_wtr_dr = 6'd5, cfg_wtr_dd = 6'd6;
  logic [1:0] cmd_kind = KO, cmd_rank = 2'd0, cmd_bg = 2'd0;
  logic       cmd_dimm = 1'b0, cmd_bc4 = 1'b0;
  logic       viol_pulse;
  logic [2:0] viol_code;
  logic [7:0] viol_gap, viol_min;

  always #2 clk = ~clk;   // 250 MHz

  ddr_turnaround_chk dut (.*);

  typedef struct {
    logic       p;
    logic [2:0] c;
    int         g;
    int         m;
    string      t;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // monitor: compares one expected item per driven cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        n_chk++;
        if (viol_pulse !== e.p || viol_code !== e.c ||
            int'(viol_gap) != e.g || int'(viol_min) != e.m) begin
          n_fail++;
          $display("FAIL %s: got pulse=%0b code=%0d gap=%0d min=%0d, expected pulse=%0b code=%0d gap=%0d min=%0d",
                   e.t, viol_pulse, viol_code, viol_gap, viol_min, e.p, e.c, e.g, e.m);
        end
      end
    end
  end

  task automatic step(input logic [1:0] k, input logic [1:0] rk, input logic dm,
                      input logic [1:0] bg, input logic bc, input logic ld,
                      input int ec, input int eg, input int em, input string tag);
    item_t e;
    @(negedge clk);
    cmd_kind = k; cmd_rank = rk; cmd_dimm = dm; cmd_bg = bg; cmd_bc4 = bc; cfg_load = ld;
    e.p = (ec != 0); e.c = 3'(ec); e.g = eg; e.m = em; e.t = tag;
    sb.push_back(e);
  endtask

  task automatic cmd(input logic [1:0] k, input logic [1:0] rk, input logic dm,
                     input logic [1:0] bg, input logic bc,
                     input int ec, input int eg, input int em, input string tag);
    step(k, rk, dm, bg, bc, 1'b0, ec, eg, em, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(KO, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 0, 0, 0, tag);
  endtask

  task automatic clr(input string tag);
    step(KO, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    n_chk++;
    if (viol_pulse !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got pulse=%0b, expected 0", viol_pulse);
    end
    @(negedge clk); rst_n = 1'b1;

    // CL=11 CWL=8 AL=0 CCD=4 WTR=6 WPRE=1: RTW 9/7, WTR 18/16, WTW 7
    clr("R10 load");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R1 first command unchecked");
    idle(1, "R9 idle");

    clr("R10 clear");
    cmd(KR, 0, 0, 0, 0, 0, 0, 0, "R2 read");
    idle(7, "R2 idle");
    cmd(KW, 0, 0, 0, 0, 1, 8, 9, "R2 rtw bl8 short");
    idle(1, "R9 one-cycle flag");

    clr("R10 clear");
    cmd(KR, 0, 0, 0, 0, 0, 0, 0, "R9 read");
    idle(8, "R9 idle");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R9 gap equal to minimum");

    clr("R10 clear");
    cmd(KR, 0, 0, 0, 1, 0, 0, 0, "R3 read bc4");
    idle(5, "R3 idle");
    cmd(KW, 0, 0, 0, 0, 1, 6, 7, "R3 rtw bc4 short");
    clr("R10 clear");
    cmd(KR, 0, 0, 0, 1, 0, 0, 0, "R3 read bc4");
    idle(6, "R3 idle");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R3 rtw bc4 met");

    clr("R10 clear");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R4 write bl8");
    idle(16, "R4 idle");
    cmd(KR, 0, 0, 0, 0, 4, 17, 18, "R4 wtr bl8 short");
    clr("R10 clear");
    cmd(KW, 0, 0, 0, 1, 0, 0, 0, "R4 write bc4");
    idle(15, "R4 idle");
    cmd(KR, 0, 0, 0, 0, 0, 0, 0, "R4 wtr bc4 met");
    clr("R10 clear");
    cmd(KW, 0, 0, 0, 1, 0, 0, 0, "R4 write bc4");
    idle(14, "R4 idle");
    cmd(KR, 0, 0, 0, 0, 4, 15, 16, "R4 wtr bc4 short");

    clr("R10 clear");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R5 write");
    idle(5, "R5 idle");
    cmd(KW, 0, 0, 0, 0, 7, 6, 7, "R5 wtw short");
    idle(6, "R5 idle");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R5 wtw met after violating write");

    clr("R10 clear");
    cmd(KR, 0, 0, 0, 0, 0, 0, 0, "R6 read");
    idle(5, "R6 idle");
    cmd(KW, 1, 0, 0, 0, 2, 6, 7, "R6 rtw other rank");
    clr("R10 clear");
    cmd(KR, 0, 0, 0, 0, 0, 0, 0, "R6 read");
    idle(7, "R6 idle");
    cmd(KW, 0, 1, 0, 0, 3, 8, 9, "R6 rtw other dimm");
    clr("R10 clear");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R6 write");
    idle(3, "R6 idle");
    cmd(KR, 1, 0, 0, 0, 5, 4, 5, "R6 wtr other rank");
    clr("R10 clear");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R6 write");
    idle(4, "R6 idle");
    cmd(KR, 0, 1, 0, 0, 6, 5, 6, "R6 wtr other dimm");
    clr("R10 clear");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R6 write");
    cmd(KW, 1, 0, 0, 0, 0, 0, 0, "R6 wtw other rank unchecked");

    clr("R10 clear");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R7 write bg0");
    idle(1, "R7 idle");
    cmd(KR, 0, 0, 1, 0, 0, 0, 0, "R7 ddr4 read other bg unchecked");
    clr("R10 clear");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R7 write bg0");
    cmd(KW, 0, 0, 1, 0, 0, 0, 0, "R7 ddr4 write other bg unchecked");
    cfg_ddr4 = 1'b0;
    clr("R10 load ddr3");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R7 ddr3 write bg0");
    idle(1, "R7 idle");
    cmd(KR, 0, 0, 2, 0, 4, 2, 18, "R7 ddr3 bg ignored");
    cfg_ddr4 = 1'b1;

    clr("R10 clear");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R11 write");
    cmd(KR, 0, 0, 0, 0, 4, 1, 18, "R11 read");
    idle(1, "R11 idle");
    cmd(KW, 0, 0, 0, 0, 1, 2, 9, "R11 rtw over wtw");

    clr("R10 clear");
    cmd(KR, 0, 0, 0, 0, 0, 0, 0, "R10 read before load");
    step(KW, 0, 0, 0, 0, 1'b1, 0, 0, 0, "R10 command on load cycle");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R10 history cleared, load command unrecorded");

    cfg_ccd = 6'd8;
    clr("R10 load ccd 8");
    cmd(KR, 0, 0, 0, 0, 0, 0, 0, "R10 read");
    idle(11, "R10 idle");
    cmd(KW, 0, 0, 0, 0, 1, 12, 13, "R10 new config applied");
    cfg_ccd = 6'd4;

    clr("R10 clear");
    cmd(KR, 0, 0, 0, 0, 0, 0, 0, "R12 read");
    idle(256, "R12 idle");
    cmd(KW, 0, 0, 0, 0, 0, 0, 0, "R12 gap saturates, no wrap");

    idle(1, "R9 idle");
    @(negedge clk); cmd_kind = KO;
    @(negedge clk); #2;
    finish_run();
  end

endmodule